// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the per-channel port that joins one voice channel to a time-division PCM bus. A frame sync pulse restarts a bit counter that runs on the bus bit clock. The channel's bit window opens at a start position made of a time-slot number, which supplies the upper bits, and a 3-bit sub-slot bit offset, which supplies the lower three bits. Inside that window the port drives its transmit sample onto the bus. In the same window it captures the receive sample from the bus. A sample is one 8-bit companded byte, which fills one slot, or one 16-bit two's complement linear word, which fills two adjacent slots.

One control byte shapes each frame. It selects bit order, linear or companded framing, and the companding law. It can force the output to high impedance or send zeros in place of data. It can replace the received sample with the idle-channel code, and it enables two loopback paths. The control byte, slot, offset and transmit sample are all captured at frame sync and hold for the rest of that frame. The host normally programs the slot of channel n to 16·n, so four channels sit in slots 0, 16, 32 and 48. A standby input forces the output to high impedance at once. Companding arithmetic and bit-clock generation are not part of this block.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset tx_oe, tx_data, rx_valid and rx_sample are all 0, and no bit window opens until the first frame sync.
- R2: Bit period 0 is the first period after the rising edge that samples fsync high. The window starts at position slot_num·8 + bit_off. It lasts 8 periods when ctrl bit 1 is 0 (companded) and 16 periods when ctrl bit 1 is 1 (linear). tx_oe is 1 for exactly the window periods.
- R3: ctrl bit 5 sets the bit order for both directions: 1 sends and receives MSB first, and 0 sends and receives LSB first.
- R4: ctrl bit 7 set holds tx_oe at 0 for the whole frame. The standby input set forces tx_oe to 0 in the same period.
- R5: ctrl bit 6 set drives tx_data to 0 for every window bit, while tx_oe stays 1.
- R6: The received sample appears on rx_sample with rx_valid high for exactly one period, the period after its last bit. In companded mode bits 15:8 of rx_sample are 0.
- R7: ctrl bit 4 set replaces the received sample with the idle code. The code is 0x00FF when ctrl bit 0 is 0 (mu-law), 0x00D5 when ctrl bit 0 is 1 (A-law), and 0x0000 in linear mode.
- R8: ctrl bit 3 set (digital loopback) transmits the value that rx_sample holds at frame sync, in place of tx_sample.
- R9: ctrl bit 2 set (analog-side loopback) returns the frame's transmit word, masked to the sample width, as the received sample. The serial input is ignored, zero insertion is not applied to the returned word, and the idle code takes priority over this loopback.
- R10: ctrl, slot_num, bit_off and tx_sample are captured at frame sync. Changes to them later in the frame have no effect until the next frame sync.
- R11: tx_data is 0 in every period in which tx_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus bit clock. Transmit bits change on its rising edge; receive bits are sampled on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, sampled high on one rising edge |
| standby | input | 1 | Forces the transmit output to high impedance immediately |
| ctrl | input | 8 | Per-frame control byte (bit fields as in R2 to R9) |
| slot_num | input | SLOT_W (8) | Time-slot number, upper bits of the start position |
| bit_off | input | OFF_W (3) | Sub-slot bit offset, lower bits of the start position |
| tx_sample | input | SAMPLE_W (16) | Transmit sample; companded mode uses bits 7:0 |
| rx_data | input | 1 | Serial receive data from the bus |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for tx_data; 0 means high impedance |
| rx_sample | output | SAMPLE_W (16) | Last received sample after idle and loopback selection |
| rx_valid | output | 1 | One-period strobe that marks a new rx_sample |

## Verification
The embedded properties check, on every clock, these relations:
- tx_data stays quiet whenever the enable is low, the enable never rises outside the window or during standby, and zero insertion holds the data low.
- rx_valid never lasts two periods, and a companded sample never carries upper bits.
- The mu-law idle code is exact, and the captured frame settings stay stable between syncs.

Other behaviour only the bench's frames can show: the exact start position built from slot and offset, bit order in both directions, the loopback data paths, and the A-law and linear idle codes. Two directed frames cover the rest. One changes the inputs in mid-frame, and one asserts standby inside the window.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

   // Control byte; the field order matches the bit positions of ctrl[7:0].
   typedef struct packed {
      logic hiz;        // bit 7: high impedance for the frame
      logic zero;       // bit 6: send zeros
      logic msb_first;  // bit 5: bit order, both directions
      logic idle;       // bit 4: idle code on receive
      logic dloop;      // bit 3: receive word looped to transmit
      logic aloop;      // bit 2: transmit word looped to receive
      logic linear;     // bit 1: 16-bit linear framing
      logic alaw;       // bit 0: A-law idle code
   } pcm_cfg_t;

   localparam logic [7:0] IDLE_MU = 8'hFF;
   localparam logic [7:0] IDLE_A  = 8'hD5;

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
   import pcm_slot_pkg::*;
#(
   parameter int SLOT_W   = 8,
   parameter int OFF_W    = 3,
   parameter int CMP_W    = 8,
   parameter int SAMPLE_W = 16,
   localparam int POS_W   = SLOT_W + OFF_W,
   localparam int CNT_W   = POS_W + 1,
   localparam int IDX_W   = $clog2(SAMPLE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic [7:0]        ctrl_in,
   input  logic [SLOT_W-1:0] slot_in,
   input  logic [OFF_W-1:0]  off_in,
   output pcm_cfg_t          cfg_o,
   output logic              win_o,
   output logic              last_o,
   output logic [IDX_W-1:0]  pos_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [POS_W-1:0] start_q;
   logic [CNT_W-1:0] offs;
   logic [CNT_W-1:0] len;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] top_idx;

   // The counter saturates, so no window can open before a sync or after a long gap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         start_q <= '0;
         cfg_o   <= '0;
      end else if (fsync) begin
         cnt_q   <= '0;
         start_q <= {slot_in, off_in};
         cfg_o   <= pcm_cfg_t'(ctrl_in);
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign offs    = cnt_q - {1'b0, start_q};
   assign len     = cfg_o.linear ? CNT_W'(SAMPLE_W) : CNT_W'(CMP_W);
   assign win_o   = (cnt_q >= {1'b0, start_q}) && (offs < len);
   assign last_o  = win_o && (offs == len - 1'b1);
   assign idx     = offs[IDX_W-1:0];
   assign top_idx = cfg_o.linear ? IDX_W'(SAMPLE_W - 1) : IDX_W'(CMP_W - 1);
   assign pos_o   = cfg_o.msb_first ? (top_idx - idx) : idx;

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync |=> $stable(cfg_o));

   // R1
   cnt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '1 && !fsync) |=> !win_o);

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
   import pcm_slot_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   localparam int IDX_W   = $clog2(SAMPLE_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fsync,
   input  logic                standby,
   input  logic                loop_sel,
   input  logic [SAMPLE_W-1:0] tx_sample,
   input  logic [SAMPLE_W-1:0] loop_word,
   input  pcm_cfg_t            cfg,
   input  logic                win,
   input  logic [IDX_W-1:0]    pos,
   output logic [SAMPLE_W-1:0] word_o,
   output logic                tx_data,
   output logic                tx_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_o <= '0;
      else if (fsync) word_o <= loop_sel ? loop_word : tx_sample;
   end

   assign tx_oe   = win && !cfg.hiz && !standby;
   assign tx_data = tx_oe && !cfg.zero && word_o[pos];

   // R11
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> !tx_data);

   // R4
   stby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !tx_oe);

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_oe && cfg.zero) |-> !tx_data);

   // R2
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_oe |-> win);

endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
   import pcm_slot_pkg::*;
#(
   parameter int CMP_W    = 8,
   parameter int SAMPLE_W = 16,
   localparam int IDX_W   = $clog2(SAMPLE_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_data,
   input  pcm_cfg_t            cfg,
   input  logic                win,
   input  logic                last,
   input  logic [IDX_W-1:0]    pos,
   input  logic [SAMPLE_W-1:0] loop_word,
   output logic [SAMPLE_W-1:0] rx_sample,
   output logic                rx_valid
);

   logic [SAMPLE_W-1:0] shift_q;
   logic [SAMPLE_W-1:0] shift_d;
   logic [SAMPLE_W-1:0] idle_w;
   logic [SAMPLE_W-1:0] mask_w;
   logic [SAMPLE_W-1:0] pick_w;

   // Each bit cell loads only when the window points at it.
   for (genvar i = 0; i < SAMPLE_W; i++) begin : g_cell
      assign shift_d[i] = (win && pos == IDX_W'(i)) ? rx_data : shift_q[i];
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= shift_d;
   end

   assign idle_w = cfg.linear ? '0 : SAMPLE_W'(cfg.alaw ? IDLE_A : IDLE_MU);
   assign mask_w = cfg.linear ? '1 : SAMPLE_W'({CMP_W{1'b1}});
   assign pick_w = cfg.idle  ? idle_w :
                   cfg.aloop ? (loop_word & mask_w) : (shift_q & mask_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid  <= 1'b0;
         rx_sample <= '0;
      end else begin
         rx_valid <= last;
         if (last) rx_sample <= pick_w;
      end
   end

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6
   cmp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !$past(cfg.linear)) |-> (rx_sample[SAMPLE_W-1:CMP_W] == '0));

   // R7
   idle_mu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(cfg.idle && !cfg.linear && !cfg.alaw)) |->
      (rx_sample == SAMPLE_W'(IDLE_MU)));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
   import pcm_slot_pkg::*;
#(
   parameter int SLOT_W   = 8,
   parameter int OFF_W    = 3,
   parameter int CMP_W    = 8,
   parameter int SAMPLE_W = 16,
   localparam int IDX_W   = $clog2(SAMPLE_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fsync,
   input  logic                standby,
   input  logic [7:0]          ctrl,
   input  logic [SLOT_W-1:0]   slot_num,
   input  logic [OFF_W-1:0]    bit_off,
   input  logic [SAMPLE_W-1:0] tx_sample,
   input  logic                rx_data,
   output logic                tx_data,
   output logic                tx_oe,
   output logic [SAMPLE_W-1:0] rx_sample,
   output logic                rx_valid
);

   if (CMP_W != 8) begin : g_bad_cmp
      $error("CMP_W must be 8: idle codes are byte values");
   end
   if (SAMPLE_W != 2 * CMP_W) begin : g_bad_lin
      $error("SAMPLE_W must span exactly two slots");
   end
   if (OFF_W != $clog2(CMP_W)) begin : g_bad_off
      $error("OFF_W must address one slot of bits");
   end

   pcm_cfg_t            cfg;
   logic                win;
   logic                last;
   logic [IDX_W-1:0]    pos;
   logic [SAMPLE_W-1:0] tx_word;
   pcm_cfg_t            cfg_next;

   assign cfg_next = pcm_cfg_t'(ctrl);

   pcm_frame_timer #(
      .SLOT_W(SLOT_W), .OFF_W(OFF_W), .CMP_W(CMP_W), .SAMPLE_W(SAMPLE_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .fsync(fsync),
      .ctrl_in(ctrl), .slot_in(slot_num), .off_in(bit_off),
      .cfg_o(cfg), .win_o(win), .last_o(last), .pos_o(pos)
   );

   pcm_tx_shifter #(.SAMPLE_W(SAMPLE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .standby(standby),
      .loop_sel(cfg_next.dloop), .tx_sample(tx_sample), .loop_word(rx_sample),
      .cfg(cfg), .win(win), .pos(pos),
      .word_o(tx_word), .tx_data(tx_data), .tx_oe(tx_oe)
   );

   pcm_rx_capture #(.CMP_W(CMP_W), .SAMPLE_W(SAMPLE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data),
      .cfg(cfg), .win(win), .last(last), .pos(pos), .loop_word(tx_word),
      .rx_sample(rx_sample), .rx_valid(rx_valid)
   );

endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;

   logic        clk = 1'b0;
   logic        rst_n, fsync, standby, rx_data;
   logic [7:0]  ctrl, slot_num;
   logic [2:0]  bit_off;
   logic [15:0] tx_sample;
   logic        tx_data, tx_oe, rx_valid;
   logic [15:0] rx_sample;

   int   n_checks = 0;
   int   n_err    = 0;
   bit   done     = 1'b0;
   logic [15:0] prev_rx = 16'h0000;

   always #4 clk = ~clk;

   pcm_slot_port u_dut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .standby(standby),
      .ctrl(ctrl), .slot_num(slot_num), .bit_off(bit_off),
      .tx_sample(tx_sample), .rx_data(rx_data),
      .tx_data(tx_data), .tx_oe(tx_oe), .rx_sample(rx_sample), .rx_valid(rx_valid)
   );

   // {ctrl, slot, offset, tx sample, rx serial word, expected rx_sample}
   localparam int NV = 16;
   localparam logic [66:0] VEC [NV] = '{
      {8'h00, 8'd0,   3'd0, 16'h00A5, 16'h003C, 16'h003C},  // LSB first companded
      {8'h20, 8'd1,   3'd3, 16'h005A, 16'h00C3, 16'h00C3},  // MSB first, offset
      {8'h02, 8'd2,   3'd0, 16'h1234, 16'hBEEF, 16'hBEEF},  // linear LSB first
      {8'h22, 8'd16,  3'd5, 16'h8001, 16'h7FFE, 16'h7FFE},  // linear MSB first
      {8'h40, 8'd3,   3'd1, 16'h00FF, 16'h0011, 16'h0011},  // zero insertion
      {8'h80, 8'd0,   3'd2, 16'h0055, 16'h0022, 16'h0022},  // high impedance
      {8'h10, 8'd4,   3'd0, 16'h0033, 16'h0044, 16'h00FF},  // idle mu-law
      {8'h11, 8'd4,   3'd0, 16'h0033, 16'h0044, 16'h00D5},  // idle A-law
      {8'h12, 8'd4,   3'd0, 16'h0033, 16'hAAAA, 16'h0000},  // idle linear
      {8'h04, 8'd1,   3'd0, 16'h1299, 16'h0077, 16'h0099},  // analog-side loop
      {8'h08, 8'd2,   3'd4, 16'h0001, 16'h0066, 16'h0066},  // digital loop sends 0x99
      {8'h0C, 8'd0,   3'd1, 16'h0002, 16'h00F0, 16'h0066},  // both loops
      {8'h14, 8'd1,   3'd0, 16'h0042, 16'h0013, 16'h00FF},  // idle beats loop
      {8'h46, 8'd2,   3'd0, 16'hCAFE, 16'h1111, 16'hCAFE},  // loop word not zeroed
      {8'h26, 8'd0,   3'd6, 16'h0F0F, 16'h2222, 16'h0F0F},  // linear MSB loop
      {8'h00, 8'd200, 3'd7, 16'h0081, 16'h0018, 16'h0018}   // high slot number
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [7:0] c);
      if (c[4])      return "R7";
      else if (c[2]) return "R9";
      else if (c[3]) return "R8";
      else if (c[6]) return "R5";
      else if (c[7]) return "R4";
      else           return "R3";
   endfunction

   // Called just after a rising edge; returns just after a rising edge.
   task automatic run_frame(input logic [7:0] c, input logic [7:0] s, input logic [2:0] o,
                            input logic [15:0] txs, input logic [15:0] rxw,
                            input logic [15:0] exp_rx, input bit stby, input bit chg,
                            input string req);
      int start = int'(s) * 8 + int'(o);
      int len   = c[1] ? 16 : 8;
      logic [15:0] word = c[3] ? prev_rx : txs;
      int bad = 0;
      int vcount = 0;
      int vpos = -1;
      logic [15:0] got = 16'h0000;
      ctrl = c; slot_num = s; bit_off = o; tx_sample = txs; fsync = 1'b1;
      @(posedge clk); #1;
      fsync = 1'b0;
      for (int p = 0; p < start + len + 2; p++) begin
         int  k   = p - start;
         bit  inw = (k >= 0) && (k < len);
         int  bi  = c[5] ? (len - 1 - k) : k;
         bit  exp_oe, exp_d;
         rx_data = inw ? rxw[bi] : 1'b0;
         standby = stby && inw && (k >= 2) && (k < 5);
         if (chg && p == 1) begin
            ctrl = 8'hC0; slot_num = 8'd0; bit_off = 3'd0; tx_sample = ~txs;
         end
         #5;
         exp_oe = inw && !c[7] && !standby;
         exp_d  = exp_oe && !c[6] && word[bi];
         if (tx_oe !== exp_oe || tx_data !== exp_d) bad++;
         if (rx_valid === 1'b1) begin
            vcount++;
            vpos = p;
            got  = rx_sample;
         end
         @(posedge clk); #1;
      end
      standby = 1'b0;
      check(bad == 0, {"R2 R11 ", req}, "serial mismatches", bad, 0);
      check(vcount == 1 && vpos == start + len, "R6", "valid count*1000+position",
            vcount * 1000 + vpos, 1000 + start + len);
      check(got === exp_rx, req, "rx_sample", got, exp_rx);
      prev_rx = exp_rx;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      int hi;
      rst_n = 1'b0; fsync = 1'b0; standby = 1'b0; rx_data = 1'b0;
      ctrl = 8'h00; slot_num = 8'd0; bit_off = 3'd0; tx_sample = 16'h0000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #5;
      check(tx_oe === 1'b0 && tx_data === 1'b0, "R1", "tx after reset", {tx_oe, tx_data}, 0);
      check(rx_valid === 1'b0 && rx_sample === 16'h0000, "R1", "rx after reset",
            {rx_valid, rx_sample}, 0);
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #6;
         if (tx_oe !== 1'b0 || rx_valid !== 1'b0) hi++;
      end
      check(hi == 0, "R1", "activity before first sync", hi, 0);
      @(posedge clk); #1;

      for (int i = 0; i < NV; i++) begin
         logic [66:0] v = VEC[i];
         run_frame(v[66:59], v[58:51], v[50:48], v[47:32], v[31:16], v[15:0],
                   1'b0, 1'b0, tag_of(v[66:59]));
      end

      // R10: inputs change in mid-frame, the frame keeps its captured settings.
      run_frame(8'h00, 8'd2, 3'd0, 16'h00B4, 16'h004B, 16'h004B, 1'b0, 1'b1, "R10");
      // R4: standby inside the window drops the enable for those periods only.
      run_frame(8'h20, 8'd1, 3'd0, 16'h0069, 16'h0096, 16'h0096, 1'b1, 1'b0, "R4");
      // R8: digital loop after the standby frame sends 0x96.
      run_frame(8'h28, 8'd0, 3'd0, 16'h0000, 16'h0005, 16'h0005, 1'b0, 1'b0, "R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule